// File: doc/BRIEF.md
# Three-wire serial EEPROM host controller

This block is the host side of a link to a three-wire serial EEPROM. A client hands it one command at a time: a command select, an address and, for writes, a data word. The controller then drives the device's chip select, serial clock and serial data input, and it reads the device's serial data output. It builds the bit frame that matches the chosen array organization, which is 16-bit words or 8-bit bytes. For reads it drops the leading zero the device sends before the data and returns the captured word. For commands that program the array, it ends the frame with a short chip-select low pulse. It then raises chip select again and polls the device's ready/busy level until the device reports ready or a timeout runs out.

The request side uses valid/ready. `req_ready` is high only while the controller is idle, and a request is taken on a clock where `req_valid` and `req_ready` are both high. Asserting `req_valid` while `req_ready` is low has no effect, so a client may hold a request and wait. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse for each accepted request, and `rsp_rdata` and `rsp_err` are valid in that cycle. The serial clock runs for `2*SCK_HALF` system clocks per bit. `CS_LOW_CYC` sets the minimum chip-select low time. `POLL_LIMIT` bounds the ready/busy polling.

Top module: `sereep_host`

## Requirements
- R1: A request opens a frame. Chip select rises with the serial clock low, and a 1 start bit is sent first. Then come the 2-bit opcode and the address, each most significant bit first. The address is `req_addr[ADDR_W-1:0]` when `org_wide`=1 and `req_addr[ADDR_W:0]` when `org_wide`=0. The `req_op` codes for address commands are 0 = read (opcode 10) and 2 = erase (opcode 11).
- R2: The whole-device commands send opcode 00 and put a 2-bit code in the two top address positions. The codes are `req_op` 3 = enable programming (11), 4 = disable programming (00), 5 = erase all (10) and 6 = write all (01). All lower address positions are sent as 0.
- R3: `req_op` 1 = write (opcode 01) and `req_op` 6 (write all) append data bits right after the address, most significant bit first. In wide organization these are all 16 bits of `req_wdata`. In narrow organization they are `req_wdata[7:0]`.
- R4: For a read, `ee_do` is sampled at each falling edge of the serial clock. The sample taken at the last address bit is the dummy zero and is dropped. The next 16 (wide) or 8 (narrow) samples form `rsp_rdata` with the first sample as the most significant bit. In narrow organization `rsp_rdata[15:8]` is 0. The data part of a read frame sends `ee_di`=0.
- R5: Within a frame, each serial clock high phase and each low phase lasts exactly `SCK_HALF` system clocks. `ee_di` changes only while the serial clock is low. The serial clock is low whenever chip select is low.
- R6: Write, erase, erase-all and write-all are programming commands. After the last bit of one of these, chip select stays low for exactly `CS_LOW_CYC` cycles. It is then raised and `ee_do` is sampled every cycle. The first 1 ends the command with `rsp_err`=0 and chip select low.
- R7: If `ee_do` does not read 1 within `POLL_LIMIT` polling cycles, the controller drops chip select and responds with `rsp_err`=1.
- R8: `req_ready` is high only when no command is in progress. A `req_valid` seen while `req_ready` is low changes neither the frame nor the response count.
- R9: Each accepted request produces exactly one `rsp_valid` pulse, one cycle long. Read, enable and disable respond at the clock where chip select falls after the frame.
- R10: `req_op` 7 is rejected. It produces a response with `rsp_err`=1 and no chip-select activity.
- R11: Chip select stays low for at least `CS_LOW_CYC` cycles before any rise.
- R12: After reset, `ee_cs`, `ee_sck`, `ee_di` and `rsp_valid` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| org_wide | input | 1 | Array organization: 1 = 16-bit words, 0 = bytes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_op | input | 3 | Command select (codes in R1 to R3, R10) |
| req_addr | input | ADDR_W+1 | Word or byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| rsp_err | output | 1 | Timeout or rejected command, valid with rsp_valid |
| ee_cs | output | 1 | Device chip select |
| ee_sck | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data and ready/busy from the device |

## Verification
A bench model of the device shifts in every frame on the rising clock edges. It returns a random word after a dummy zero on reads, and it stays busy for a random number of cycles after programming commands. The bench tries all seven commands in both organizations with random addresses and data. Comparing frames bit for bit separates errors in the opcode, the prefix code, the address width and the data width. Random read words expose an off-by-one around the dummy bit, and random busy lengths exercise the polling exit. Directed cases add a device that never becomes ready, the rejected command code, and a request held valid while the controller is busy.

// File: rtl/sereep_pkg.sv
`timescale 1ns/1ps
package sereep_pkg;
  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ERASE     = 3'd2,
    OP_PROG_ON   = 3'd3,
    OP_PROG_OFF  = 3'd4,
    OP_ERASE_ALL = 3'd5,
    OP_WRITE_ALL = 3'd6,
    OP_RSVD      = 3'd7
  } host_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SHIFT,
    S_GAP,
    S_POLL,
    S_REST
  } host_state_e;
endpackage

// File: rtl/sereep_sck_gen.sv
`timescale 1ns/1ps
module sereep_sck_gen #(
  parameter int HALF = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/sereep_frame.sv
`timescale 1ns/1ps
module sereep_frame
  import sereep_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int FRAME_W = ADDR_W + 19,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  host_op_e           op,
  input  logic [ADDR_W:0]    addr,
  input  logic [15:0]        wdata,
  input  logic               wide,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   cmd_len,
  output logic [LEN_W-1:0]   tot_len,
  output logic               is_read,
  output logic               is_prog,
  output logic               bad
);
  logic [1:0]        opc;
  logic [1:0]        code;
  logic              special;
  logic              has_data;
  logic [ADDR_W-1:0] a_w;
  logic [ADDR_W:0]   a_n;
  logic [15:0]       d;
  logic [LEN_W-1:0]  dw;

  always_comb begin
    opc      = 2'b00;
    code     = 2'b00;
    special  = 1'b0;
    has_data = 1'b0;
    is_read  = 1'b0;
    is_prog  = 1'b0;
    bad      = 1'b0;
    case (op)
      OP_READ:      begin opc = 2'b10; is_read = 1'b1; end
      OP_WRITE:     begin opc = 2'b01; has_data = 1'b1; is_prog = 1'b1; end
      OP_ERASE:     begin opc = 2'b11; is_prog = 1'b1; end
      OP_PROG_ON:   begin special = 1'b1; code = 2'b11; end
      OP_PROG_OFF:  begin special = 1'b1; code = 2'b00; end
      OP_ERASE_ALL: begin special = 1'b1; code = 2'b10; is_prog = 1'b1; end
      OP_WRITE_ALL: begin special = 1'b1; code = 2'b01; has_data = 1'b1; is_prog = 1'b1; end
      default:      bad = 1'b1;
    endcase

    a_w = special ? (ADDR_W'(code) << (ADDR_W - 2)) : addr[ADDR_W-1:0];
    a_n = special ? ((ADDR_W + 1)'(code) << (ADDR_W - 1)) : addr;
    d   = has_data ? wdata : 16'h0000;

    if (wide) frame = {1'b1, opc, a_w, d};
    else      frame = {1'b1, opc, a_n, d[7:0], 7'b0000000};

    cmd_len = wide ? LEN_W'(3 + ADDR_W) : LEN_W'(4 + ADDR_W);
    dw      = wide ? LEN_W'(16) : LEN_W'(8);
    tot_len = cmd_len + ((is_read || has_data) ? dw : '0);
  end
endmodule

// File: rtl/sereep_host.sv
`timescale 1ns/1ps
module sereep_host
  import sereep_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int SCK_HALF   = 13,
  parameter int CS_LOW_CYC = 13,
  parameter int POLL_LIMIT = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              org_wide,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W:0]   req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              ee_cs,
  output logic              ee_sck,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int FRAME_W  = ADDR_W + 19;
  localparam int LEN_W    = $clog2(FRAME_W + 1);
  localparam int WAIT_MAX = (POLL_LIMIT > CS_LOW_CYC) ? POLL_LIMIT : CS_LOW_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  host_state_e        state;
  logic [FRAME_W-1:0] f_frame;
  logic [LEN_W-1:0]   f_cmd_len;
  logic [LEN_W-1:0]   f_tot_len;
  logic               f_read;
  logic               f_prog;
  logic               f_bad;

  logic [FRAME_W-1:0] sreg;
  logic [LEN_W-1:0]   bit_idx;
  logic [LEN_W-1:0]   cmd_len_q;
  logic [LEN_W-1:0]   last_q;
  logic               rd_q;
  logic               prog_q;
  logic               phase_q;
  logic [WAIT_W-1:0]  wcnt;
  logic               tick;

  sereep_frame #(
    .ADDR_W (ADDR_W),
    .FRAME_W(FRAME_W),
    .LEN_W  (LEN_W)
  ) u_frame (
    .op     (host_op_e'(req_op)),
    .addr   (req_addr),
    .wdata  (req_wdata),
    .wide   (org_wide),
    .frame  (f_frame),
    .cmd_len(f_cmd_len),
    .tot_len(f_tot_len),
    .is_read(f_read),
    .is_prog(f_prog),
    .bad    (f_bad)
  );

  sereep_sck_gen #(
    .HALF(SCK_HALF)
  ) u_sck (
    .clk (clk),
    .rst (rst),
    .run (state == S_SHIFT),
    .tick(tick)
  );

  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      sreg      <= '0;
      bit_idx   <= '0;
      cmd_len_q <= '0;
      last_q    <= '0;
      rd_q      <= 1'b0;
      prog_q    <= 1'b0;
      phase_q   <= 1'b0;
      wcnt      <= '0;
      ee_cs     <= 1'b0;
      ee_sck    <= 1'b0;
      ee_di     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            rsp_rdata <= '0;
            wcnt      <= '0;
            if (f_bad) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              state     <= S_REST;
            end else begin
              rsp_err   <= 1'b0;
              ee_cs     <= 1'b1;
              ee_sck    <= 1'b0;
              ee_di     <= f_frame[FRAME_W-1];
              sreg      <= f_frame << 1;
              bit_idx   <= '0;
              phase_q   <= 1'b0;
              cmd_len_q <= f_cmd_len;
              last_q    <= f_tot_len - LEN_W'(1);
              rd_q      <= f_read;
              prog_q    <= f_prog;
              state     <= S_SHIFT;
            end
          end
        end
        S_SHIFT: begin
          if (tick) begin
            if (!phase_q) begin
              ee_sck  <= 1'b1;
              phase_q <= 1'b1;
            end else begin
              ee_sck  <= 1'b0;
              phase_q <= 1'b0;
              if (rd_q && (bit_idx >= cmd_len_q))
                rsp_rdata <= {rsp_rdata[14:0], ee_do};
              if (bit_idx == last_q) begin
                ee_cs <= 1'b0;
                ee_di <= 1'b0;
                wcnt  <= '0;
                if (prog_q) begin
                  state <= S_GAP;
                end else begin
                  rsp_valid <= 1'b1;
                  state     <= S_REST;
                end
              end else begin
                bit_idx <= bit_idx + LEN_W'(1);
                ee_di   <= sreg[FRAME_W-1];
                sreg    <= sreg << 1;
              end
            end
          end
        end
        S_GAP: begin
          if (wcnt == WAIT_W'(CS_LOW_CYC - 1)) begin
            ee_cs <= 1'b1;
            wcnt  <= '0;
            state <= S_POLL;
          end else begin
            wcnt <= wcnt + WAIT_W'(1);
          end
        end
        S_POLL: begin
          if (ee_do) begin
            ee_cs     <= 1'b0;
            rsp_valid <= 1'b1;
            wcnt      <= '0;
            state     <= S_REST;
          end else if (wcnt == WAIT_W'(POLL_LIMIT - 1)) begin
            ee_cs     <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            wcnt      <= '0;
            state     <= S_REST;
          end else begin
            wcnt <= wcnt + WAIT_W'(1);
          end
        end
        S_REST: begin
          if (wcnt == WAIT_W'(CS_LOW_CYC - 1)) state <= S_IDLE;
          else                                 wcnt  <= wcnt + WAIT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> !ee_sck); // R5
  AST_DI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ee_sck && $past(ee_sck)) |-> $stable(ee_di)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    ee_cs |-> !req_ready); // R8
  AST_CS_OPENS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> !ee_sck); // R1
endmodule

// File: tb/sereep_host_test.sv
`timescale 1ns/1ps
module sereep_host_test;
  localparam int AW   = 6;
  localparam int HALF = 3;
  localparam int CSL  = 5;
  localparam int PLIM = 400;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic          org_wide;
  logic          req_valid;
  logic          req_ready;
  logic [2:0]    req_op;
  logic [AW:0]   req_addr;
  logic [15:0]   req_wdata;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic          rsp_err;
  logic          ee_cs, ee_sck, ee_di;
  logic          do_r = 1'b0;

  sereep_host #(.ADDR_W(AW), .SCK_HALF(HALF), .CS_LOW_CYC(CSL), .POLL_LIMIT(PLIM)) uut (
    .clk(clk), .rst(rst), .org_wide(org_wide),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_di(ee_di), .ee_do(do_r)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // device model and monitors
  logic        prev_sk = 0, prev_cs = 0, prev_di = 0, prev_rv = 0;
  int          sk_run = 0, cs_low_run = 1000;
  logic [63:0] cap = 0, last_frame = 0;
  int          ncap = 0, last_len = 0, frames = 0, rsp_cnt = 0;
  logic [15:0] last_rdata = 0;
  logic        last_err = 0;
  logic [15:0] mdl_word = 0;
  bit          mdl_prog = 0, mdl_wide = 1, poll_ph = 0, is_rd = 0;
  int          mdl_busy_len = 0, busy = 0;

  always @(negedge clk) begin
    int cl, dw;
    cl = mdl_wide ? 3 + AW : 4 + AW;
    dw = mdl_wide ? 16 : 8;
    if (rst) begin
      prev_sk = 0; prev_cs = 0; prev_di = 0; prev_rv = 0;
      sk_run = 0; ncap = 0; poll_ph = 0; do_r = 0;
    end else begin
      if (ee_sck != prev_sk) begin
        check(sk_run == HALF, "R5", "serial clock phase length", sk_run, HALF);
        sk_run = 1;
      end else if (ee_cs) sk_run++;
      else sk_run = 0;
      if (!ee_cs && ee_sck) check(0, "R5", "clock high with cs low", 1, 0);
      if (ee_sck && prev_sk && ee_di != prev_di) check(0, "R5", "di moved while clock high", ee_di, prev_di);

      if (ee_cs && !prev_cs) begin
        check(cs_low_run >= CSL, "R11", "cs low time", cs_low_run, CSL);
        if (poll_ph) check(cs_low_run == CSL, "R6", "cs low pulse before poll", cs_low_run, CSL);
        ncap = 0; cap = 0; is_rd = 0;
      end
      if (!ee_cs) cs_low_run++; else cs_low_run = 0;

      if (ee_sck && !prev_sk) begin
        cap = {cap[62:0], ee_di};
        ncap++;
        if (ncap == cl) begin
          is_rd = (cap[cl-2] == 1'b1) && (cap[cl-3] == 1'b0);
          if (is_rd) do_r = 1'b0;
        end else if (is_rd && ncap > cl && ncap <= cl + dw) begin
          do_r = mdl_word[dw-1-(ncap-cl-1)];
        end
      end

      if (!ee_cs && prev_cs) begin
        if (ncap > 0) begin
          last_frame = cap; last_len = ncap; frames++;
          if (mdl_prog) begin poll_ph = 1; busy = mdl_busy_len; end
        end else poll_ph = 0;
        do_r = 0; is_rd = 0;
      end
      if (busy > 0) busy--;
      if (poll_ph && ee_cs) do_r = (busy == 0);

      if (rsp_valid) begin
        if (prev_rv) check(0, "R9", "response longer than one cycle", 2, 1);
        rsp_cnt++; last_rdata = rsp_rdata; last_err = rsp_err;
      end
      prev_sk = ee_sck; prev_cs = ee_cs; prev_di = ee_di; prev_rv = rsp_valid;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  function automatic void exp_frame(input int op, input logic [AW:0] a, input logic [15:0] d,
                                    input bit wide, output logic [63:0] f, output int n);
    int aw = wide ? AW : AW + 1;
    int dwid = wide ? 16 : 8;
    logic [1:0] opc = 2'b00, code = 2'b00;
    bit spec = 0, dat = 0, rd = 0;
    case (op)
      0: begin opc = 2'b10; rd = 1; end
      1: begin opc = 2'b01; dat = 1; end
      2: opc = 2'b11;
      3: begin spec = 1; code = 2'b11; end
      4: begin spec = 1; code = 2'b00; end
      5: begin spec = 1; code = 2'b10; end
      default: begin spec = 1; code = 2'b01; dat = 1; end
    endcase
    f = {63'd0, 1'b1}; n = 1;
    f = {f[62:0], opc[1]}; f = {f[62:0], opc[0]}; n += 2;
    for (int i = aw - 1; i >= 0; i--) begin
      logic b;
      if (spec) b = (i == aw - 1) ? code[1] : (i == aw - 2) ? code[0] : 1'b0;
      else      b = a[i];
      f = {f[62:0], b}; n++;
    end
    if (dat) for (int i = dwid - 1; i >= 0; i--) begin f = {f[62:0], d[i]}; n++; end
    if (rd)  for (int i = 0; i < dwid; i++) begin f = {f[62:0], 1'b0}; n++; end
  endfunction

  task automatic run_txn(input int op, input logic [AW:0] a, input logic [15:0] d,
                         input bit wide, input int busy_len, input int junk);
    int f0, r0, n;
    logic [63:0] f;
    bit prog, to;
    string tag;
    while (!req_ready) step();
    prog = (op == 1 || op == 2 || op == 5 || op == 6);
    to   = prog && (busy_len > PLIM + CSL + 2);
    org_wide = wide; mdl_wide = wide; mdl_prog = prog;
    mdl_busy_len = busy_len; mdl_word = 16'($urandom);
    f0 = frames; r0 = rsp_cnt;
    req_valid = 1; req_op = 3'(op); req_addr = a; req_wdata = d;
    step();
    if (op != 7) check(!req_ready, "R8", "ready low while busy", req_ready, 0);
    if (junk > 0) begin
      req_op = 3'd4; req_addr = ~a; req_wdata = ~d;
      repeat (junk) step();
    end
    req_valid = 0;
    while (rsp_cnt == r0) step();
    repeat (CSL + 3) step();
    check(rsp_cnt == r0 + 1, "R9", "one response per request", rsp_cnt - r0, 1);
    if (op == 7) begin
      check(frames == f0, "R10", "no frame for rejected code", frames - f0, 0);
      check(last_err == 1'b1, "R10", "rejected code error flag", last_err, 1);
    end else begin
      exp_frame(op, a, d, wide, f, n);
      tag = (op == 1 || op == 6) ? "R3" : (op >= 3) ? "R2" : "R1";
      check(frames == f0 + 1, (junk > 0) ? "R8" : tag, "frame count", frames - f0, 1);
      check(last_len == n, tag, "frame length", last_len, n);
      check(last_frame == f, tag, "frame bits", last_frame, f);
      if (op == 0)
        check(last_rdata == (wide ? mdl_word : {8'h00, mdl_word[7:0]}), "R4", "read data",
              last_rdata, wide ? mdl_word : {8'h00, mdl_word[7:0]});
      if (to) begin
        check(last_err == 1'b1, "R7", "timeout error flag", last_err, 1);
        check(ee_cs == 1'b0, "R7", "cs low after timeout", ee_cs, 0);
      end else begin
        check(last_err == 1'b0, prog ? "R6" : "R9", "error flag clear", last_err, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    rst = 1; org_wide = 1; req_valid = 0; req_op = 0; req_addr = 0; req_wdata = 0;
    repeat (5) step();
    rst = 0;
    step();
    check(ee_cs == 0 && ee_sck == 0 && ee_di == 0, "R12", "serial pins after reset",
          {ee_cs, ee_sck, ee_di}, 0);
    check(rsp_valid == 0, "R12", "no response after reset", rsp_valid, 0);
    check(req_ready == 1, "R12", "ready after reset", req_ready, 1);

    run_txn(3, 7'h00, 16'h0, 1, 0, 0);
    run_txn(0, 7'h2a, 16'h0, 1, 0, 0);
    run_txn(0, 7'h55, 16'h0, 0, 0, 0);
    run_txn(1, 7'h13, 16'hbeef, 1, 40, 0);
    run_txn(1, 7'h7f, 16'h12c3, 0, 2, 0);
    run_txn(5, 7'h00, 16'h0, 1, 150, 0);
    run_txn(6, 7'h00, 16'ha5f0, 0, 60, 0);
    run_txn(2, 7'h01, 16'h0, 1, 100000, 0);
    run_txn(7, 7'h11, 16'h0, 1, 0, 0);
    run_txn(0, 7'h3c, 16'h0, 1, 0, 30);
    run_txn(4, 7'h7f, 16'hffff, 0, 0, 0);

    for (int i = 0; i < 40; i++) begin
      int op = $urandom_range(0, 7);
      run_txn(op, 7'($urandom), 16'($urandom), 1'($urandom_range(0, 1)),
              $urandom_range(1, 200), 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule